// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table stored in memory, starting from the outer table. The caller hands in a virtual address and the base number of the current process's outer table, using a valid/ready handshake. The walker then makes two word reads, one after the other, on a simple memory port. Each read is a request that waits for a grant, followed by a response that may arrive any number of cycles later. The walker returns either the physical address or a fault that names the table level where the walk failed.

Pages are 1 KB. The low 10 bits of the virtual address are the page offset and pass through unchanged. The upper 22 bits hold two indices: bits [31:20] index the outer table and bits [19:10] index the inner table. Every table entry is one 32-bit word. Bit 0 is the valid flag. Bits [31:10] hold a 22-bit number: in an outer entry this is the inner table base, and in an inner entry it is the frame number. Bits [9:1] are ignored. The byte address of an entry is (base number << 10) + index × 4.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, mem_req_o is 0 and rsp_valid_o is 0.
- R2: The first read of a walk is at address {req_ptbr_i, 10'b0} + vaddr[31:20] × 4.
- R3: After a valid outer entry E, the second read is at address {E[31:10], 10'b0} + vaddr[19:10] × 4. No other read belongs to the walk.
- R4: If the inner entry I has bit 0 set, the response carries rsp_fault_o = 0, rsp_fault_lvl_o = 0 and rsp_paddr_o = {I[31:10], vaddr[9:0]}.
- R5: If the outer entry has bit 0 clear, the response carries rsp_fault_o = 1 and rsp_fault_lvl_o = 0, and no second read is issued.
- R6: If the inner entry has bit 0 clear, the response carries rsp_fault_o = 1 and rsp_fault_lvl_o = 1.
- R7: While mem_req_o is high and mem_gnt_i is low, mem_req_o stays high and mem_addr_o does not change in the next cycle.
- R8: req_ready_o is high only while the walker is idle. The address and base are captured when the request is accepted. Changes to the request inputs during a walk, including a held req_valid_i, do not affect the walk.
- R9: rsp_valid_o and the response fields stay stable until rsp_ready_i is seen. In the cycle after that, rsp_valid_o is 0 and req_ready_o is 1.
- R10: Only one read is outstanding at a time: mem_req_o stays low from a grant until its mem_rvalid_i. A mem_rvalid_i that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to take a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_ptbr_i | input | 22 | Outer table base number (address >> 10) |
| mem_req_o | output | 1 | Memory read request |
| mem_gnt_i | input | 1 | Memory accepted the request this cycle |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (table entry) |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Page fault |
| rsp_fault_lvl_o | output | 1 | Faulting level: 0 outer, 1 inner |

## Verification
Some properties are checked by the assertions on every cycle. These are the memory request holding its address until it is granted, the response holding until it is taken, the single outstanding read, and ready being raised only when no read or response is pending. The assertions also check the outer entry address, and that an outer fault ends the walk after exactly one read while a completed inner lookup takes exactly two. Other behaviour can be shown only by the bench scenarios, which use a memory model with its own grant and read latencies. These are the correct inner entry address and physical address computed from table contents, the level reported by each fault, the handling of index and offset values at their extremes, request inputs that change during a walk, and stray read data arriving while the walker is idle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  // entry = one word of 2**ENT_SH bytes
  localparam int ENT_SH = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUT,
    ST_WT_OUT,
    ST_RD_IN,
    ST_WT_IN,
    ST_DONE
  } walk_st_e;

  function automatic int max_w(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pt_idx_split.sv
module pt_idx_split #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int IN_W  = 10,
  localparam int OUT_W = VA_W - OFF_W - IN_W
) (
  input  logic [VA_W-1:0]  va_i,
  output logic [OUT_W-1:0] p_out_o,
  output logic [IN_W-1:0]  p_in_o,
  output logic [OFF_W-1:0] off_o
);
  assign p_out_o = va_i[VA_W-1 -: OUT_W];
  assign p_in_o  = va_i[OFF_W +: IN_W];
  assign off_o   = va_i[OFF_W-1:0];
endmodule

// File: rtl/pt_ent_addr.sv
module pt_ent_addr
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int IDX_W = 12,
  localparam int NUM_W = VA_W - OFF_W
) (
  input  logic [NUM_W-1:0] base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [VA_W-1:0]  addr_o
);
  logic [VA_W-1:0] tbl_base;
  logic [VA_W-1:0] byte_off;

  assign tbl_base = {base_i, {OFF_W{1'b0}}};
  assign byte_off = VA_W'({idx_i, {ENT_SH{1'b0}}});
  assign addr_o   = tbl_base + byte_off;
endmodule

// File: rtl/pt_pte_check.sv
module pt_pte_check #(
  parameter int ENT_W = 32,
  parameter int NUM_W = 22
) (
  input  logic [ENT_W-1:0] word_i,
  output logic             ok_o,
  output logic [NUM_W-1:0] num_o
);
  logic unused_rsvd;

  assign ok_o        = word_i[0];
  assign num_o       = word_i[ENT_W-1 -: NUM_W];
  assign unused_rsvd = ^word_i[ENT_W-NUM_W-1:1];
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_gnt_i,
  input  logic mem_rvalid_i,
  input  logic pte_ok_i,
  input  logic rsp_ready_i,
  output logic req_ready_o,
  output logic mem_req_o,
  output logic accept_o,
  output logic out_ok_o,
  output logic out_bad_o,
  output logic in_done_o,
  output logic lvl_in_o,
  output logic rsp_valid_o
);
  walk_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid_i)  st_d = ST_RD_OUT;
      ST_RD_OUT: if (mem_gnt_i)    st_d = ST_WT_OUT;
      ST_WT_OUT: if (mem_rvalid_i) st_d = pte_ok_i ? ST_RD_IN : ST_DONE;
      ST_RD_IN:  if (mem_gnt_i)    st_d = ST_WT_IN;
      ST_WT_IN:  if (mem_rvalid_i) st_d = ST_DONE;
      ST_DONE:   if (rsp_ready_i)  st_d = ST_IDLE;
      default:                     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;
  assign mem_req_o   = (st_q == ST_RD_OUT) || (st_q == ST_RD_IN);
  assign lvl_in_o    = (st_q == ST_RD_IN) || (st_q == ST_WT_IN);
  assign out_ok_o    = (st_q == ST_WT_OUT) && mem_rvalid_i && pte_ok_i;
  assign out_bad_o   = (st_q == ST_WT_OUT) && mem_rvalid_i && !pte_ok_i;
  assign in_done_o   = (st_q == ST_WT_IN) && mem_rvalid_i;
  assign rsp_valid_o = (st_q == ST_DONE);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int IN_W  = 10,
  parameter int ENT_W = 32,
  localparam int NUM_W = VA_W - OFF_W,
  localparam int OUT_W = NUM_W - IN_W,
  localparam int IDX_W = max_w(OUT_W, IN_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [NUM_W-1:0] req_ptbr_i,
  output logic             mem_req_o,
  input  logic             mem_gnt_i,
  output logic [VA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [ENT_W-1:0] mem_rdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [VA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             rsp_fault_lvl_o
);
  logic [VA_W-1:0]  va_q;
  logic [NUM_W-1:0] base_q;   // outer base, then inner base
  logic [VA_W-1:0]  paddr_q;
  logic             fault_q, lvl_q;

  logic [OUT_W-1:0] p_out;
  logic [IN_W-1:0]  p_in;
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic             pte_ok;
  logic [NUM_W-1:0] pte_num;
  logic             accept, out_ok, out_bad, in_done, lvl_in;

  pt_idx_split #(.VA_W(VA_W), .OFF_W(OFF_W), .IN_W(IN_W)) u_split (
    .va_i    (va_q),
    .p_out_o (p_out),
    .p_in_o  (p_in),
    .off_o   (off)
  );

  assign idx = lvl_in ? IDX_W'(p_in) : IDX_W'(p_out);

  pt_ent_addr #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .base_i (base_q),
    .idx_i  (idx),
    .addr_o (mem_addr_o)
  );

  pt_pte_check #(.ENT_W(ENT_W), .NUM_W(NUM_W)) u_pte (
    .word_i (mem_rdata_i),
    .ok_o   (pte_ok),
    .num_o  (pte_num)
  );

  pt_walk_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .pte_ok_i     (pte_ok),
    .rsp_ready_i  (rsp_ready_i),
    .req_ready_o  (req_ready_o),
    .mem_req_o    (mem_req_o),
    .accept_o     (accept),
    .out_ok_o     (out_ok),
    .out_bad_o    (out_bad),
    .in_done_o    (in_done),
    .lvl_in_o     (lvl_in),
    .rsp_valid_o  (rsp_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q   <= '0;
      base_q <= '0;
    end else if (accept) begin
      va_q   <= req_vaddr_i;
      base_q <= req_ptbr_i;
    end else if (out_ok) begin
      base_q <= pte_num;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_q <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else if (out_bad) begin
      paddr_q <= '0;
      fault_q <= 1'b1;
      lvl_q   <= 1'b0;
    end else if (in_done) begin
      paddr_q <= pte_ok ? {pte_num, off} : '0;
      fault_q <= !pte_ok;
      lvl_q   <= !pte_ok;
    end
  end

  assign rsp_paddr_o     = paddr_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_fault_lvl_o = lvl_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int IN_W  = 10,
  localparam int NUM_W = VA_W - OFF_W,
  localparam int OUT_W = NUM_W - IN_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic [NUM_W-1:0] req_ptbr_i,
  input logic             mem_req_o,
  input logic             mem_gnt_i,
  input logic [VA_W-1:0]  mem_addr_o,
  input logic             mem_rvalid_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [VA_W-1:0]  rsp_paddr_o,
  input logic             rsp_fault_o,
  input logic             rsp_fault_lvl_o
);
  logic [1:0]       rd_cnt;
  logic             pend;
  logic [VA_W-1:0]  va_c;
  logic [NUM_W-1:0] pb_c;
  logic [VA_W-1:0]  exp_outer;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt <= '0;
      pend   <= 1'b0;
      va_c   <= '0;
      pb_c   <= '0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        rd_cnt <= '0;
        va_c   <= req_vaddr_i;
        pb_c   <= req_ptbr_i;
      end else if (mem_req_o && mem_gnt_i) begin
        rd_cnt <= rd_cnt + 2'd1;
      end
      if (mem_req_o && mem_gnt_i) pend <= 1'b1;
      else if (mem_rvalid_i)      pend <= 1'b0;
    end
  end

  assign exp_outer = {pb_c, {OFF_W{1'b0}}} + VA_W'({va_c[VA_W-1 -: OUT_W], 2'b00});

  assert_outer_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && rd_cnt == 2'd0) |-> (mem_addr_o == exp_outer));

  assert_inner_reads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rd_cnt == 2'd2));

  assert_outer_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o && !rsp_fault_lvl_o) |-> (rd_cnt == 2'd1 && !mem_req_o));

  assert_inner_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o && rsp_fault_lvl_o) |-> (rd_cnt == 2'd2));

  assert_hold_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_ready_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !rsp_valid_o && !pend));

  assert_hold_rsp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_paddr_o)
      && $stable(rsp_fault_o) && $stable(rsp_fault_lvl_o)));

  assert_one_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> !mem_req_o);
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .IN_W(IN_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_vaddr_i     (req_vaddr_i),
  .req_ptbr_i      (req_ptbr_i),
  .mem_req_o       (mem_req_o),
  .mem_gnt_i       (mem_gnt_i),
  .mem_addr_o      (mem_addr_o),
  .mem_rvalid_i    (mem_rvalid_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_paddr_o     (rsp_paddr_o),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_fault_lvl_o (rsp_fault_lvl_o)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        rst_ni;
  logic        req_valid_i, req_ready_o;
  logic [31:0] req_vaddr_i;
  logic [21:0] req_ptbr_i;
  logic        mem_req_o, mem_gnt_i, mem_rvalid_i;
  logic [31:0] mem_addr_o, mem_rdata_i;
  logic        rsp_valid_o, rsp_ready_i, rsp_fault_o, rsp_fault_lvl_o;
  logic [31:0] rsp_paddr_o;

  pt_walker u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_vaddr_i, .req_ptbr_i,
    .mem_req_o, .mem_gnt_i, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .rsp_valid_o, .rsp_ready_i, .rsp_paddr_o, .rsp_fault_o, .rsp_fault_lvl_o
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", rq, what);
    end
  endtask

  // memory image and model
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_q [$];
  int          gnt_dly = 0, lat = 0, rd_idx = 0;
  logic        gnt_r = 0, rv_r = 0, stray_rv = 0;
  logic [31:0] rd_r = '0, cap_a = '0, e;
  bit          pend = 0;
  int          gw = 0, lc = 0;
  logic        snap_req = 0, snap_gnt = 0;
  logic [31:0] snap_addr = '0;

  assign mem_gnt_i    = gnt_r;
  assign mem_rvalid_i = rv_r | stray_rv;
  assign mem_rdata_i  = rv_r ? rd_r : 32'hDEAD_BEEF;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] pte(input logic [21:0] num, input bit v);
    return {num, 9'h155, v};
  endfunction

  function automatic logic [31:0] outer_a(input logic [21:0] pb, input logic [31:0] va);
    return {pb, 10'b0} + {20'b0, va[31:20], 2'b0};
  endfunction

  function automatic logic [31:0] inner_a(input logic [31:0] oe, input logic [31:0] va);
    return {oe[31:10], 10'b0} + {20'b0, va[19:10], 2'b0};
  endfunction

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      gnt_r = 0; rv_r = 0; pend = 0; gw = 0; snap_req = 0; snap_gnt = 0;
    end else begin
      if (snap_req && !snap_gnt)
        chk(mem_req_o && mem_addr_o == snap_addr, "R7",
            $sformatf("req %b addr %h exp 1 %h", mem_req_o, mem_addr_o, snap_addr));
      rv_r = 0;
      if (gnt_r) begin
        gnt_r = 0; pend = 1; lc = lat;
        if (exp_q.size() == 0) chk(0, "R5", $sformatf("read %h exp none", cap_a));
        else begin
          e = exp_q.pop_front();
          chk(cap_a == e, rd_idx == 0 ? "R2" : "R3", $sformatf("addr %h exp %h", cap_a, e));
        end
        rd_idx++;
        chk(!mem_req_o, "R10", $sformatf("req %b exp 0", mem_req_o));
      end else if (pend) begin
        chk(!mem_req_o, "R10", $sformatf("req %b exp 0", mem_req_o));
        if (lc == 0) begin rv_r = 1; rd_r = rd(cap_a); pend = 0; end
        else lc--;
      end else if (mem_req_o) begin
        if (gw >= gnt_dly) begin gnt_r = 1; cap_a = mem_addr_o; gw = 0; end
        else gw++;
      end
      snap_req = mem_req_o; snap_gnt = gnt_r; snap_addr = mem_addr_o;
    end
  end

  task automatic map(input logic [21:0] pb, input logic [31:0] va, input logic [21:0] ib,
                     input bit ov, input logic [21:0] fr, input bit iv);
    logic [31:0] oe;
    oe = pte(ib, ov);
    mem[outer_a(pb, va)] = oe;
    mem[inner_a(oe, va)] = pte(fr, iv);
  endtask

  task automatic walk(input logic [31:0] va, input logic [21:0] pb, input int gd,
                      input int lt, input int rdel, input bit scr);
    logic [31:0] oa, oe, ie, exp_pa, pa_s;
    bit exp_f, exp_l, f_s, l_s;
    oa = outer_a(pb, va);
    oe = rd(oa);
    exp_q.delete();
    exp_q.push_back(oa);
    exp_pa = '0; exp_f = 1; exp_l = 0;
    if (oe[0]) begin
      exp_q.push_back(inner_a(oe, va));
      ie = rd(inner_a(oe, va));
      exp_l = !ie[0]; exp_f = !ie[0];
      if (ie[0]) exp_pa = {ie[31:10], va[9:0]};
    end
    gnt_dly = gd; lat = lt; rd_idx = 0;
    req_vaddr_i = va; req_ptbr_i = pb; req_valid_i = 1;
    chk(req_ready_o === 1'b1, "R8", $sformatf("ready %b exp 1", req_ready_o));
    @(negedge clk_i);
    if (scr) begin req_vaddr_i = ~va; req_ptbr_i = ~pb; end
    else req_valid_i = 0;
    while (!rsp_valid_o) begin
      chk(req_ready_o === 1'b0, "R8", $sformatf("ready %b exp 0 during walk", req_ready_o));
      @(negedge clk_i);
    end
    pa_s = rsp_paddr_o; f_s = rsp_fault_o; l_s = rsp_fault_lvl_o;
    if (!exp_f)
      chk(!f_s && !l_s && pa_s == exp_pa, "R4",
          $sformatf("f %b l %b pa %h exp 0 0 %h", f_s, l_s, pa_s, exp_pa));
    else if (!exp_l)
      chk(f_s && !l_s, "R5", $sformatf("f %b l %b exp 1 0", f_s, l_s));
    else
      chk(f_s && l_s, "R6", $sformatf("f %b l %b exp 1 1", f_s, l_s));
    for (int i = 0; i < rdel; i++) begin
      @(negedge clk_i);
      chk(rsp_valid_o && rsp_paddr_o == pa_s && rsp_fault_o == f_s && rsp_fault_lvl_o == l_s,
          "R9", $sformatf("v %b pa %h exp 1 %h", rsp_valid_o, rsp_paddr_o, pa_s));
    end
    rsp_ready_i = 1; req_valid_i = 0;
    @(negedge clk_i);
    rsp_ready_i = 0;
    chk(!rsp_valid_o && req_ready_o, "R9",
        $sformatf("v %b rdy %b exp 0 1", rsp_valid_o, req_ready_o));
    chk(exp_q.size() == 0, (exp_f && !exp_l) ? "R5" : "R3",
        $sformatf("reads left %0d exp 0", exp_q.size()));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; req_valid_i = 0; req_vaddr_i = '0; req_ptbr_i = '0; rsp_ready_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(req_ready_o && !mem_req_o && !rsp_valid_o, "R1",
        $sformatf("rdy %b req %b v %b exp 1 0 0", req_ready_o, mem_req_o, rsp_valid_o));

    // R2 R3 R4: plain walk, zero delays
    map(22'h00040, 32'h1231_16AB, 22'h00100, 1, 22'h3ABCD, 1);
    walk(32'h1231_16AB, 22'h00040, 0, 0, 0, 0);
    // R7 R9: grant stall, read latency, response back-pressure
    walk(32'h1231_16AB, 22'h00040, 2, 3, 3, 0);
    // R5: outer entry invalid
    mem[outer_a(22'h00050, 32'h4560_0000)] = pte(22'h12345, 0);
    walk(32'h4560_0000, 22'h00050, 1, 2, 1, 0);
    // R6: inner entry invalid
    map(22'h00060, 32'h7890_5555, 22'h00200, 1, 22'h2AAAA, 0);
    walk(32'h7890_5555, 22'h00060, 0, 1, 0, 0);
    // boundary: all-ones indices and offset
    map(22'h3FFF0, 32'hFFFF_FFFF, 22'h3FFC00, 1, 22'h3FFFFF, 1);
    walk(32'hFFFF_FFFF, 22'h3FFF0, 1, 0, 0, 0);
    // boundary: all-zero indices, base 0
    map(22'h0, 32'h0000_0000, 22'h00001, 1, 22'h00002, 1);
    walk(32'h0000_0000, 22'h0, 0, 0, 2, 0);
    // R8: inputs change and valid stays high during the walk
    map(22'h00070, 32'hABC0_0C01, 22'h00300, 1, 22'h15555, 1);
    walk(32'hABC0_0C01, 22'h00070, 2, 2, 1, 1);
    // R10: stray read data while idle
    @(negedge clk_i);
    stray_rv = 1;
    @(negedge clk_i);
    stray_rv = 0;
    chk(!rsp_valid_o && req_ready_o && !mem_req_o, "R10",
        $sformatf("v %b rdy %b req %b exp 0 1 0", rsp_valid_o, req_ready_o, mem_req_o));
    walk(32'h1231_16AB, 22'h00040, 0, 0, 0, 0);
    // back-to-back walks with varied timing
    for (int k = 0; k < 6; k++) begin
      map(22'(22'h01000 + k), {12'(k * 37), 10'(k * 91), 10'(k * 5)}, 22'(22'h20000 + k * 3),
          1, 22'(22'h0F0F0 + k), (k != 4));
      walk({12'(k * 37), 10'(k * 91), 10'(k * 5)}, 22'(22'h01000 + k), k % 3, k % 4, k % 2, k[0]);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule